// File: doc/BRIEF.md
# PC-indexed branch history table

This block predicts whether a conditional branch will be taken. It keeps a small table of prediction entries. The low-order bits of the branch address select an entry, and no tag is checked. Two branches whose addresses agree in those low bits therefore land on the same entry and train it together. The aliasing is intended, so that its effect on accuracy can be studied.

A parameter picks the entry type. In last-outcome mode each entry is one bit holding the most recent resolved direction. In hysteresis mode each entry is a two-bit saturating counter, so a single surprise does not reverse a strong prediction.

The lookup port is combinational: an address goes in and a taken bit comes out. The training port takes a resolved branch address and its direction, and the table is written at the next clock edge. Two free-running statistics counters count trained branches and mispredicted branches, so the miss rate of a branch stream can be read directly.

Top module: `bht_predictor`

## Requirements
- R1: The entry index is `pc[IDX_W-1:0]` with no alignment bits dropped (pc bit 0 is index bit 0). Addresses that agree in these bits share one entry, and training through one of them changes the prediction seen through the other.
- R2: After reset every entry predicts not taken, and `branchCount` and `missCount` are zero.
- R3: With `TWO_BIT=0`, each entry is one bit that holds the last resolved outcome (1 = taken). It starts at 0 (not taken) and predicts its own value.
- R4: With `TWO_BIT=1`, each entry is a counter encoded 0 = strongly not taken, 1 = weakly not taken, 2 = weakly taken, 3 = strongly taken. It resets to 1 and predicts taken when the value is 2 or 3. A taken outcome adds one and saturates at 3; a not-taken outcome subtracts one and saturates at 0.
- R5: With `TWO_BIT=1`, one not-taken outcome on a strongly taken entry leaves it weakly taken, and the entry still predicts taken.
- R6: `branchCount` increases by one on every clock edge where `updValid` is high and holds otherwise. Both counters wrap modulo 2^CNT_W.
- R7: `missCount` increases by one on an update whose `updTaken` differs from the prediction held by the entry of `updPc` before that update. Otherwise it holds.
- R8: `predTaken` is a combinational function of `predPc` and the table. An update becomes visible only after the clock edge that accepts it, so a lookup of the same entry in the same cycle returns the old prediction.
- R9: Consider an inner branch with the pattern taken, taken, taken, not taken, followed by an aliased outer branch that is taken, starting from reset. In last-outcome mode this gives 3 misses in the first outer iteration and 2 of 5 in each later one. In hysteresis mode it gives 2 of 5 in the first outer iteration and 1 of 5 in each later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| predPc | input | PC_W | Address to predict |
| predTaken | output | 1 | Prediction for `predPc`, 1 = taken |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved direction, 1 = taken |
| branchCount | output | CNT_W | Number of updates accepted |
| missCount | output | CNT_W | Number of updates that were mispredicted |

## Verification
The bench drives two addresses that differ only above the index bits through a nested-loop pattern. It checks the per-iteration miss counts in both modes: a design that indexed with high bits or stripped bit 0 would not alias, and one with a wrong hysteresis rule would give the wrong 2/1 or 3/2 figures. Directed steps check the counter at both saturation ends and the strong-taken-then-not-taken step. A counter that wrapped would predict the wrong direction there, and one without hysteresis would flip to not taken. A lookup of the entry being trained in the same cycle must still show the old value, and a miss must be judged against the pre-update entry. Seeded random updates on a wider address range are then compared against a bench model of both modes.

// File: rtl/bht_pkg.sv
package bht_pkg;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic wrEn;
    logic bumpBranch;
    logic bumpMiss;
  } bhtStrobe_t;

  // Hysteresis counter encoding (R4).
  localparam logic [1:0] CTR_STRONG_NT = 2'd0;
  localparam logic [1:0] CTR_WEAK_NT   = 2'd1;
  localparam logic [1:0] CTR_WEAK_T    = 2'd2;
  localparam logic [1:0] CTR_STRONG_T  = 2'd3;

  // Saturating step of a hysteresis counter.
  function automatic logic [1:0] ctrStep(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_STRONG_T) nxt = cur + 2'd1;
    end else begin
      if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bht_ctrl.sv
module bht_ctrl
  import bht_pkg::*;
#(
  parameter int ENT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             updValid,
  input  logic             updTaken,
  input  logic [ENT_W-1:0] curEntry,
  output bhtStrobe_t       strobe,
  output logic [ENT_W-1:0] nextEntry
);

  logic curPred;

  assign curPred = curEntry[ENT_W-1];

  generate
    if (ENT_W == 2) begin : g_hyst
      // R4: two-bit saturating counter
      always_comb nextEntry = ctrStep(curEntry[1:0], updTaken);
    end else begin : g_last
      // R3: last outcome overwrites the entry
      always_comb nextEntry = updTaken;
    end
  endgenerate

  always_comb begin
    strobe.wrEn       = updValid;
    strobe.bumpBranch = updValid;
    strobe.bumpMiss   = updValid && (curPred != updTaken);
  end

  // R7: a miss is always also a counted branch.
  assert_miss_is_branch_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bumpMiss |-> strobe.bumpBranch);

endmodule

// File: rtl/bht_datapath.sv
module bht_datapath
  import bht_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int ENT_W = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] predIdx,
  input  logic [IDX_W-1:0] updIdx,
  input  bhtStrobe_t       strobe,
  input  logic [ENT_W-1:0] nextEntry,
  output logic [ENT_W-1:0] predEntry,
  output logic [ENT_W-1:0] updEntry,
  output logic [CNT_W-1:0] branchCount,
  output logic [CNT_W-1:0] missCount
);

  localparam int ENTRIES = 1 << IDX_W;
  // Weakly not taken (1) in hysteresis mode, not taken (0) in last-outcome mode.
  localparam logic [ENT_W-1:0] RST_VAL = ENT_W'(ENT_W - 1);

  logic [ENT_W-1:0] entryQ [ENTRIES];

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          entryQ[e] <= RST_VAL;
        end else if (strobe.wrEn && (updIdx == IDX_W'(e))) begin
          entryQ[e] <= nextEntry;
        end
      end
    end
  endgenerate

  assign predEntry = entryQ[predIdx];
  assign updEntry  = entryQ[updIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      branchCount <= '0;
      missCount   <= '0;
    end else begin
      if (strobe.bumpBranch) branchCount <= branchCount + CNT_W'(1);
      if (strobe.bumpMiss)   missCount   <= missCount + CNT_W'(1);
    end
  end

  assert_branch_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bumpBranch |=> branchCount == $past(branchCount) + CNT_W'(1));

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.bumpBranch |=> $stable(branchCount) && $stable(missCount));

  assert_miss_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bumpMiss |=> missCount == $past(missCount) + CNT_W'(1));

  assert_miss_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.bumpMiss |=> $stable(missCount));

endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
  import bht_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 16,
  parameter bit TWO_BIT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  predPc,
  output logic             predTaken,
  input  logic             updValid,
  input  logic [PC_W-1:0]  updPc,
  input  logic             updTaken,
  output logic [CNT_W-1:0] branchCount,
  output logic [CNT_W-1:0] missCount
);

  localparam int ENT_W = TWO_BIT ? 2 : 1;

  logic [IDX_W-1:0] predIdx;
  logic [IDX_W-1:0] updIdx;
  logic [ENT_W-1:0] predEntry;
  logic [ENT_W-1:0] updEntry;
  logic [ENT_W-1:0] nextEntry;
  bhtStrobe_t       strobe;

  // R1: low address bits, bit 0 included
  assign predIdx   = predPc[IDX_W-1:0];
  assign updIdx    = updPc[IDX_W-1:0];
  assign predTaken = predEntry[ENT_W-1];

  bht_ctrl #(.ENT_W(ENT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .updValid  (updValid),
    .updTaken  (updTaken),
    .curEntry  (updEntry),
    .strobe    (strobe),
    .nextEntry (nextEntry)
  );

  bht_datapath #(.IDX_W(IDX_W), .ENT_W(ENT_W), .CNT_W(CNT_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .predIdx     (predIdx),
    .updIdx      (updIdx),
    .strobe      (strobe),
    .nextEntry   (nextEntry),
    .predEntry   (predEntry),
    .updEntry    (updEntry),
    .branchCount (branchCount),
    .missCount   (missCount)
  );

  // R8: lookup of the same address in a held cycle is stable when nothing trains.
  assert_pred_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(updValid) && $stable(predPc)) |-> $stable(predTaken));

endmodule

// File: tb/bht_predictor_tb_top.sv
module bht_predictor_tb_top;

  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int CNT_W = 16;
  localparam int NENT  = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [PC_W-1:0]  predPc = '0;
  logic             updValid = 1'b0;
  logic [PC_W-1:0]  updPc = '0;
  logic             updTaken = 1'b0;
  logic             predT2, predT1;
  logic [CNT_W-1:0] brC2, missC2, brC1, missC1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model
  logic [1:0] m2 [NENT];
  logic       m1 [NENT];
  int modelBr = 0, modelMiss2 = 0, modelMiss1 = 0;

  always #2 clk = ~clk;  // 250 MHz

  bht_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .TWO_BIT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predT2),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .branchCount(brC2), .missCount(missC2));

  bht_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .TWO_BIT(1'b0)) dut1b_i (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predT1),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .branchCount(brC1), .missCount(missC1));

  function automatic logic [1:0] modelStep(input logic [1:0] s, input logic t);
    if (t) return (s == 2'd3) ? 2'd3 : s + 2'd1;
    return (s == 2'd0) ? 2'd0 : s - 2'd1;
  endfunction

  function automatic int idxOf(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W-1:0]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One resolved branch, with lookup of the same address in the same cycle.
  task automatic doBranch(input logic [PC_W-1:0] pc, input logic t);
    int i;
    logic p2, p1;
    i = idxOf(pc);
    @(negedge clk);
    predPc = pc; updPc = pc; updTaken = t; updValid = 1'b1;
    #1;
    p2 = m2[i][1];
    p1 = m1[i];
    check(predT2 == p2, "R8/R4 pre-update prediction (2-bit)", int'(predT2), int'(p2));
    check(predT1 == p1, "R8/R3 pre-update prediction (1-bit)", int'(predT1), int'(p1));
    @(posedge clk);
    #1;
    updValid = 1'b0;
    modelBr++;
    if (p2 != t) modelMiss2++;
    if (p1 != t) modelMiss1++;
    m2[i] = modelStep(m2[i], t);
    m1[i] = t;
    check(predT2 == m2[i][1], "R8 post-update prediction (2-bit)", int'(predT2), int'(m2[i][1]));
    check(predT1 == m1[i], "R8 post-update prediction (1-bit)", int'(predT1), int'(m1[i]));
    check(int'(brC2) == (modelBr % 65536), "R6 branch count (2-bit)", int'(brC2), modelBr);
    check(int'(brC1) == (modelBr % 65536), "R6 branch count (1-bit)", int'(brC1), modelBr);
    check(int'(missC2) == (modelMiss2 % 65536), "R7 miss count (2-bit)", int'(missC2), modelMiss2);
    check(int'(missC1) == (modelMiss1 % 65536), "R7 miss count (1-bit)", int'(missC1), modelMiss1);
  endtask

  task automatic peek(input logic [PC_W-1:0] pc, output logic p2, output logic p1);
    @(negedge clk);
    predPc = pc;
    #1;
    p2 = predT2;
    p1 = predT1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic p2, p1;
    int m2Before, m1Before;
    void'($urandom(32'd20240517));
    for (int i = 0; i < NENT; i++) begin
      m2[i] = 2'd1;
      m1[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R2: reset state
    check(brC2 == '0 && brC1 == '0, "R2 branch counters zero", int'(brC2) + int'(brC1), 0);
    check(missC2 == '0 && missC1 == '0, "R2 miss counters zero", int'(missC2) + int'(missC1), 0);
    for (int i = 0; i < NENT; i++) begin
      peek(PC_W'(i), p2, p1);
      check(p2 == 1'b0 && p1 == 1'b0, "R2 entry predicts not taken", int'(p2) + int'(p1), 0);
    end

    // R9 + R1: nested loop, inner 0x29 and outer 0x39 share index 9
    for (int it = 0; it < 4; it++) begin
      m2Before = modelMiss2;
      m1Before = modelMiss1;
      doBranch(32'h29, 1'b1);
      doBranch(32'h29, 1'b1);
      doBranch(32'h29, 1'b1);
      doBranch(32'h29, 1'b0);
      doBranch(32'h39, 1'b1);
      check(int'(missC2) - m2Before == ((it == 0) ? 2 : 1), "R9 hysteresis misses per iteration",
            int'(missC2) - m2Before, (it == 0) ? 2 : 1);
      check(int'(missC1) - m1Before == ((it == 0) ? 3 : 2), "R9 last-outcome misses per iteration",
            int'(missC1) - m1Before, (it == 0) ? 3 : 2);
    end

    // R5: strongly taken then one not taken stays taken in 2-bit mode
    doBranch(32'h5, 1'b1);
    doBranch(32'h5, 1'b1);
    doBranch(32'h5, 1'b0);
    peek(32'h5, p2, p1);
    check(p2 == 1'b1, "R5 weakened entry still predicts taken", int'(p2), 1);
    check(p1 == 1'b0, "R3 last outcome not taken", int'(p1), 0);

    // R4: saturation at strongly not taken, then two takens to cross
    doBranch(32'h6, 1'b0);
    doBranch(32'h6, 1'b0);
    doBranch(32'h6, 1'b0);
    doBranch(32'h6, 1'b1);
    peek(32'h6, p2, p1);
    check(p2 == 1'b0, "R4 one taken from saturated not taken", int'(p2), 0);
    check(p1 == 1'b1, "R3 last outcome taken", int'(p1), 1);
    doBranch(32'h6, 1'b1);
    peek(32'h6, p2, p1);
    check(p2 == 1'b1, "R4 second taken reaches weakly taken", int'(p2), 1);

    // R1: aliasing through bit 0 and the high bits
    doBranch(32'h13, 1'b1);
    doBranch(32'h13, 1'b1);
    peek(32'hF003, p2, p1);
    check(p2 == 1'b1 && p1 == 1'b1, "R1 alias 0xF003 sees training of 0x13", int'(p2) + int'(p1), 2);
    peek(32'h2, p2, p1);
    check(p2 == 1'b0 && p1 == 1'b0, "R1 index 2 untouched", int'(p2) + int'(p1), 0);

    // Random phase: model comparison for R3, R4, R6, R7, R8
    for (int n = 0; n < 400; n++) begin
      logic [PC_W-1:0] pc;
      logic t;
      pc = PC_W'($urandom & 32'hFF);
      t = ($urandom % 4) != 0;
      doBranch(pc, t);
      if (($urandom % 5) == 0) repeat (2) @(posedge clk);
    end

    // R6: idle cycles leave counters unchanged
    repeat (5) @(posedge clk);
    #1;
    check(int'(brC2) == modelBr, "R6 counters hold when idle", int'(brC2), modelBr);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule